// File: doc/BRIEF.md
# Serial Configuration Loader with Chain Pass-Through

This block takes a configuration image one bit at a time on a serial data input. The input is sampled on the rising edge of a clock that comes from outside the block. The idle line level is high. A frame starts with a single low start bit, which is not stored, followed by exactly `FRAME_BITS` payload bits. The payload bits go into a register array that stands in for the configuration store. When the last payload bit is captured, the done flag rises.

After that, the block stops absorbing data and becomes a one-stage pipe. Every bit sampled on the data input is re-driven on the data output after the same rising edge. Several loaders can therefore hang off one source, each loader's data output feeding the next loader's data input. The stream is simply the frames laid end to end, and each frame carries its own start bit. While a loader is still filling its own store, its data output stays at the idle level, so the loader after it waits.

A three-pin mode decoder enables the function only for code 3'b111. Any other code freezes the loader where it is. The active-low program input works as a synchronous restart. When it is sampled low, the block clears the bit counter and the store, drops done and stops forwarding.

Top module: `serial_cfg_loader`

## Requirements
- R1: A rising edge that samples `prog_n` low leaves `done` = 0, `dout` = 1 and `cfg_image` all zeros, and the block then waits for a start bit.
- R2: While waiting, a sampled `din` of 1 has no effect. The first sampled 0 is the start bit. It begins a frame and is not written to the store.
- R3: The k-th payload bit after the start bit (k counted from 0) is written to `cfg_image[k]`. Bits that have not yet arrived read as 0.
- R4: `done` rises after exactly the edge that samples payload bit `FRAME_BITS-1`, and not earlier.
- R5: While `done` is 0, `dout` is 1.
- R6: Once `done` is 1, the value of `din` sampled at each rising edge appears on `dout` right after that edge, and `cfg_image` no longer changes.
- R7: `serial_mode` is 1 exactly when `mode_pins` = 3'b111. While it is 0, no bit is captured, counted or forwarded and `dout` holds. Loading resumes where it stopped when the code returns to 3'b111.
- R8: Taking `prog_n` low after `done` has risen stops forwarding (`dout` returns to 1) and clears `done`, and a new frame can then be loaded.
- R9: Two loaders chained output-to-input on one clock take consecutive frames from one stream: the upstream loader gets the first frame, the downstream loader gets the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Externally supplied configuration clock; data sampled on its rising edge |
| prog_n | input | 1 | Active-low synchronous program/restart |
| mode_pins | input | 3 | Mode select code; 3'b111 enables serial loading |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next loader in the chain |
| done | output | 1 | High once this loader's frame is complete |
| serial_mode | output | 1 | High when the mode code selects serial loading |
| cfg_image | output | FRAME_BITS | Contents of the configuration store, bit k = k-th payload bit |

## Verification
The bench chains two loaders. The upstream loader is built with `FRAME_BITS` = 16 and the downstream one with `FRAME_BITS` = 8. The unequal lengths show that the hand-off does not depend on one frame size. They also show that the downstream frame ends partway through the stream, one edge behind the upstream forwarding stage. Short frames let many random rounds fit, each with random idle gaps, and still leave room for all-ones and all-zeros corner frames and a mode change partway through a frame.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOAD = 2'd1,
        ST_PASS = 2'd2
    } ld_state_e;

    typedef enum logic {
        MODE_SER_SLAVE  = 1'b0,
        MODE_UNSUPPORTED = 1'b1
    } cfg_mode_e;

    typedef struct packed {
        logic capture;
        logic forward;
    } ld_ctrl_t;

    localparam logic [2:0] MODE_CODE_SER_SLAVE = 3'b111;
    localparam logic       LINE_IDLE           = 1'b1;
    localparam logic       START_LEVEL         = 1'b0;

    function automatic cfg_mode_e decode_mode(input logic [2:0] pins);
        return (pins == MODE_CODE_SER_SLAVE) ? MODE_SER_SLAVE : MODE_UNSUPPORTED;
    endfunction

endpackage

// File: rtl/scl_mode_dec.sv
module scl_mode_dec
    import scl_pkg::*;
(
    input  logic [2:0] mode_pins,
    output cfg_mode_e  mode
);
    always_comb mode = decode_mode(mode_pins);
endmodule

// File: rtl/scl_frame_ctl.sv
module scl_frame_ctl
    import scl_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    localparam int IW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          din,
    output ld_ctrl_t      ctrl,
    output logic [IW-1:0] wr_idx,
    output logic          done
);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    ld_state_e     state;
    logic [IW-1:0] cnt;
    logic          last_bit;

    always_comb begin
        ctrl.capture = en && (state == ST_LOAD);
        ctrl.forward = en && (state == ST_PASS);
        last_bit     = ctrl.capture && (cnt == LAST_IDX);
        wr_idx       = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (en) begin
            unique case (state)
                ST_HUNT: if (din == START_LEVEL) state <= ST_LOAD;
                ST_LOAD: begin
                    if (last_bit) begin
                        state <= ST_PASS;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PASS: state <= ST_PASS;
                default: state <= ST_HUNT;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_IDX);                                              // R3
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt) && $stable(state) && $stable(done)));    // R7
    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == ST_LOAD);                      // R4

endmodule

// File: rtl/scl_store.sv
module scl_store #(
    parameter int FRAME_BITS = 32,
    localparam int IW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IW-1:0]         idx,
    input  logic                  d,
    output logic [FRAME_BITS-1:0] image
);
    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                          image[i] <= 1'b0;
            else if (we && idx == IW'(i))     image[i] <= d;
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(idx) < FRAME_BITS));                              // R3
endmodule

// File: rtl/scl_fwd.sv
module scl_fwd
    import scl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fwd,
    input  logic din,
    output logic dout
);
    always_ff @(posedge clk) begin
        if (rst)      dout <= LINE_IDLE;
        else if (fwd) dout <= din;
    end

    AST_HOLD_UNLESS_FWD: assert property (@(posedge clk) disable iff (rst)
        !fwd |=> $stable(dout));                                       // R7
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    localparam int IW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic                  cfg_clk,
    input  logic                  prog_n,
    input  logic [2:0]            mode_pins,
    input  logic                  din,
    output logic                  dout,
    output logic                  done,
    output logic                  serial_mode,
    output logic [FRAME_BITS-1:0] cfg_image
);
    logic          rst;
    cfg_mode_e     mode;
    ld_ctrl_t      ctrl;
    logic [IW-1:0] wr_idx;

    assign rst         = ~prog_n;
    assign serial_mode = (mode == MODE_SER_SLAVE);

    scl_mode_dec u_mode (
        .mode_pins (mode_pins),
        .mode      (mode)
    );

    scl_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_ctl (
        .clk    (cfg_clk),
        .rst    (rst),
        .en     (serial_mode),
        .din    (din),
        .ctrl   (ctrl),
        .wr_idx (wr_idx),
        .done   (done)
    );

    scl_store #(.FRAME_BITS(FRAME_BITS)) u_store (
        .clk   (cfg_clk),
        .rst   (rst),
        .we    (ctrl.capture),
        .idx   (wr_idx),
        .d     (din),
        .image (cfg_image)
    );

    scl_fwd u_fwd (
        .clk  (cfg_clk),
        .rst  (rst),
        .fwd  (ctrl.forward),
        .din  (din),
        .dout (dout)
    );

    AST_IDLE_UNTIL_DONE: assert property (@(posedge cfg_clk) disable iff (rst)
        !done |-> dout == LINE_IDLE);                                  // R5
    AST_IMAGE_FROZEN: assert property (@(posedge cfg_clk) disable iff (rst)
        (done && $past(done)) |-> $stable(cfg_image));                 // R6
    AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (rst)
        done |=> done);                                                // R8

endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
    localparam int NA = 16;
    localparam int NB = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          prog_n;
    logic [2:0]    mode;
    logic          din;
    logic          dout_a, done_a, sm_a, dout_b, done_b, sm_b;
    logic [NA-1:0] img_a;
    logic [NB-1:0] img_b;

    int n_chk = 0;
    int n_fail = 0;

    serial_cfg_loader #(.FRAME_BITS(NA)) dut_i (
        .cfg_clk(clk), .prog_n(prog_n), .mode_pins(mode), .din(din),
        .dout(dout_a), .done(done_a), .serial_mode(sm_a), .cfg_image(img_a));

    serial_cfg_loader #(.FRAME_BITS(NB)) dn_i (
        .cfg_clk(clk), .prog_n(prog_n), .mode_pins(mode), .din(dout_a),
        .dout(dout_b), .done(done_b), .serial_mode(sm_b), .cfg_image(img_b));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] partial(input logic [63:0] frame, input int k);
        logic [63:0] m;
        m = (k >= 64) ? '1 : ((64'd1 << k) - 64'd1);
        return frame & m;
    endfunction

    task automatic tick(input logic d);
        din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart();
        prog_n = 1'b0;
        tick(1'b1);
        prog_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NA-1:0] fa;
        logic [NB-1:0] fb;
        int gap;
        void'($urandom(32'd4242));
        prog_n = 1'b0;
        mode   = 3'b111;
        din    = 1'b1;
        @(negedge clk);
        restart();
        // R1 reset state
        check("R1 done", done_a, 0);
        check("R1 dout", dout_a, 1);
        check("R1 image", img_a, 0);
        check("R7 serial_mode", sm_a, 1);

        for (int r = 0; r < 6; r++) begin
            restart();
            fa = NA'($urandom);
            fb = NB'($urandom);
            if (r == 0) begin fa = '1; fb = '0; end
            if (r == 1) begin fa = '0; fb = '1; end
            gap = int'($urandom % 7);
            for (int i = 0; i < gap; i++) tick(1'b1);
            check("R2 idle ignored image", img_a, 0);
            check("R2 idle ignored done", done_a, 0);
            tick(1'b0);
            check("R2 start not stored", img_a, 0);
            for (int i = 0; i < NA; i++) begin
                tick(fa[i]);
                if (i == 0) check("R3 first bit", img_a, partial(64'(fa), 1));
                if (i < NA - 1) begin
                    check("R4 done early", done_a, 0);
                    check("R5 dout idle", dout_a, 1);
                end
            end
            check("R4 done at last bit", done_a, 1);
            check("R3 image order", img_a, fa);
            check("R9 downstream waiting", done_b, 0);
            // idle gap forwarded as ones
            gap = int'($urandom % 4);
            for (int i = 0; i < gap; i++) begin
                tick(1'b1);
                check("R6 fwd idle", dout_a, 1);
            end
            tick(1'b0);
            check("R6 fwd start", dout_a, 0);
            for (int i = 0; i < NB; i++) begin
                tick(fb[i]);
                check("R6 fwd bit", dout_a, fb[i]);
            end
            check("R9 downstream one edge behind", done_b, 0);
            tick(1'b1);
            check("R9 downstream done", done_b, 1);
            check("R9 downstream image", img_b, fb);
            check("R6 upstream image frozen", img_a, fa);
        end

        // R8: restart after done
        check("R8 precondition done", done_a, 1);
        tick(1'b0);
        check("R8 forwarding before restart", dout_a, 0);
        restart();
        check("R8 done cleared", done_a, 0);
        check("R8 dout idle", dout_a, 1);
        check("R8 image cleared", img_a, 0);
        tick(1'b0);
        tick(1'b0);
        check("R8 no forward after restart", dout_a, 1);

        // R7: mode change mid-frame
        restart();
        fa = NA'($urandom);
        tick(1'b0);
        for (int i = 0; i < 5; i++) tick(fa[i]);
        mode = 3'b011;
        #1;
        check("R7 serial_mode off", sm_a, 0);
        for (int i = 0; i < 4; i++) tick(1'($urandom));
        check("R7 frozen image", img_a, partial(64'(fa), 5));
        check("R7 frozen done", done_a, 0);
        check("R7 frozen dout", dout_a, 1);
        mode = 3'b111;
        #1;
        check("R7 serial_mode on", sm_a, 1);
        for (int i = 5; i < NA; i++) tick(fa[i]);
        check("R7 resumed image", img_a, fa);
        check("R7 resumed done", done_a, 1);
        // frozen while forwarding
        mode = 3'b110;
        tick(1'b0);
        check("R7 no forward when off", dout_a, 1);
        mode = 3'b111;
        tick(1'b0);
        check("R6 forward after mode back", dout_a, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule